// File: doc/BRIEF.md
# Glitch-Rejecting Pulse Width Capture

This block measures the width of a single positive-going pulse on an asynchronous input. The unit of measurement is a tick from a divide-by-125 prescaler that runs off the system clock. With an 8.192 MHz clock, the tick rate is 65.536 kHz, which gives a resolution of 1/65536 s.

A processor arms a measurement with a write cycle. A write is chip select low with the read/write strobe low. Arming clears the count. The block then waits for the input to be low, so that it never starts in the middle of a pulse. It accepts the next rising edge as the start and counts ticks while the input stays high.

Each edge is confirmed on the following tick. A lone high sample at the start is treated as noise, and the block goes back to waiting. A lone low sample during counting is also treated as noise, and counting resumes.

When two low samples in a row end the pulse, the block does three things:
- It pulls the active-low interrupt down.
- It returns to idle.
- It ignores the input until the next arming write.

The processor reads the count with a read cycle, which is chip select low with the strobe high. The read also releases the interrupt.

Top module: `pulse_width_capture`

## Requirements
- R1: A capture tick occurs once every PRESCALE (default 125) clocks. It is made by a phase flop that toggles at prescaler counts 1 and 1+(PRESCALE+1)/2 (64 by default). The input passes through a two-flop synchronizer and is sampled only on ticks. A clean pulse covering H tick samples measures H-1.
- R2: An arming write (cs_n=0, rw=0, sampled on a clock edge) does the following in any state: it clears the count to zero, releases the interrupt, and puts the block in the armed state.
- R3: After arming, a high sample does not start a measurement until at least one low sample has been seen since the write.
- R4: A single high sample followed by a low sample is rejected. The count stays zero, no interrupt is raised, and the block keeps waiting for a start.
- R5: The sample that confirms the start adds the first count. Each later high sample in the counting state adds one more.
- R6: A single low sample followed by a high sample resumes counting. That high sample adds no count. Each later high sample adds one.
- R7: Two consecutive low samples end the measurement and drive irq_n to 0. The block then ignores the input until the next arming write.
- R8: irq_n stays low until a read cycle or an arming write. It returns to 1 on the clock after either.
- R9: rdata equals the count while cs_n=0 and rw=1. Otherwise rdata is zero.
- R10: The count saturates at all ones and does not wrap.
- R11: A synchronous active-high rst does three things: it forces the idle state (code 000), clears the count, and sets irq_n to 1. The state codes are idle 000, armed 001, start-confirm 010, count 011 and end-confirm 100. The codes 101, 110 and 111 return to idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 1 = read, 0 = write (arm) |
| pulse_in | input | 1 | Asynchronous pulse to measure |
| irq_n | output | 1 | Active-low measurement-done interrupt |
| rdata | output | CNT_W | Count during read cycles, else zero |

## Verification
The bench changes the input half-way between ticks, so every pulse maps to an exact number of tick samples.

It arms while the input is already high. A design that skips the low-first rule would report the tail of that pulse instead of the next one.

It also sends a one-tick spike before a real pulse, and a one-tick dropout inside a pulse:
- A design without the start confirmation would raise the interrupt on the spike.
- A design that stops at the first low sample would report a short count.
- A design that counts the resuming sample would report one too many.

Pulses that arrive after a capture must leave the count and the interrupt untouched. A narrow-counter instance holds a long pulse, which exposes a counter that wraps.

// File: rtl/pulse_width_capture.sv
module pulse_width_capture #(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 125
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rw,
  input  logic             pulse_in,
  output logic             irq_n,
  output logic [CNT_W-1:0] rdata
);

  localparam int              PS_W    = $clog2(PRESCALE);
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
  localparam logic [PS_W-1:0] TOG_A   = PS_W'(1);
  localparam logic [PS_W-1:0] TOG_B   = PS_W'(1 + (PRESCALE + 1) / 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  localparam logic [2:0] S_IDLE  = 3'b000;
  localparam logic [2:0] S_ARMED = 3'b001;
  localparam logic [2:0] S_LEAD  = 3'b010;
  localparam logic [2:0] S_RUN   = 3'b011;
  localparam logic [2:0] S_TRAIL = 3'b100;

  logic [PS_W-1:0]  ps_cnt;
  logic             phase, phase_d, tick;
  logic [1:0]       sync_q;
  logic             smp;
  logic [2:0]       state, nxt;
  logic             low_seen;
  logic [CNT_W-1:0] cnt;
  logic             arm_wr, rd_en, inc, end_meas;

  assign arm_wr = ~cs_n & ~rw;
  assign rd_en  = ~cs_n & rw;
  assign tick   = phase & ~phase_d;
  assign smp    = sync_q[1];
  assign rdata  = rd_en ? cnt : '0;

  // prescaler and tick phase flop
  always_ff @(posedge clk) begin
    if (rst) begin
      ps_cnt  <= '0;
      phase   <= 1'b0;
      phase_d <= 1'b0;
    end else begin
      ps_cnt  <= (ps_cnt == PS_LAST) ? '0 : ps_cnt + 1'b1;
      if (ps_cnt == TOG_A || ps_cnt == TOG_B) phase <= ~phase;
      phase_d <= phase;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[0], pulse_in};
  end

  always_comb begin
    nxt      = state;
    inc      = 1'b0;
    end_meas = 1'b0;
    case (state)
      S_IDLE:  nxt = S_IDLE;
      S_ARMED: if (tick && smp && low_seen) nxt = S_LEAD;
      S_LEAD:  if (tick) begin
                 nxt = smp ? S_RUN : S_ARMED;
                 inc = smp;
               end
      S_RUN:   if (tick) begin
                 if (smp) inc = 1'b1;
                 else     nxt = S_TRAIL;
               end
      S_TRAIL: if (tick) begin
                 if (smp) nxt = S_RUN;
                 else begin
                   nxt      = S_IDLE;
                   end_meas = 1'b1;
                 end
               end
      default: nxt = S_IDLE;
    endcase
    if (arm_wr) begin
      nxt      = S_ARMED;
      inc      = 1'b0;
      end_meas = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst || arm_wr)                          low_seen <= 1'b0;
    else if (state == S_ARMED && tick && !smp)  low_seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || arm_wr)               cnt <= '0;
    else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                  irq_n <= 1'b1;
    else if (end_meas)        irq_n <= 1'b0;
    else if (arm_wr || rd_en) irq_n <= 1'b1;
  end

  assert_count_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
    (!tick && !arm_wr) |=> $stable(cnt));

  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (rst)
    arm_wr |=> (cnt == '0 && state == S_ARMED && irq_n));

  assert_no_start_before_low_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_ARMED && !low_seen && !arm_wr) |=> state != S_LEAD);

  assert_end_raises_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_TRAIL && tick && !smp && !arm_wr) |=> (!irq_n && state == S_IDLE));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !arm_wr) |=> (state == S_IDLE && $stable(cnt)));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !arm_wr) |=> cnt == CNT_MAX);

  assert_unused_recover_R11: assert property (@(posedge clk) disable iff (rst)
    (state > S_TRAIL && !arm_wr) |=> state == S_IDLE);

endmodule

// File: tb/sim_pulse_width_capture.sv
module sim_pulse_width_capture;
  localparam int TK = 125;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rw = 1'b1, pin = 1'b0;
  logic irq_n, irq1_n;
  logic [15:0] rdata;
  logic [3:0]  rdata1;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  pulse_width_capture u0 (.clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw),
                          .pulse_in(pin), .irq_n(irq_n), .rdata(rdata));
  pulse_width_capture #(.CNT_W(4)) u1 (.clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw),
                          .pulse_in(pin), .irq_n(irq1_n), .rdata(rdata1));

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n * TK) @(negedge clk);
  endtask

  task automatic align;
    do @(negedge clk); while (cyc % TK != 60);
  endtask

  task automatic arm;
    @(negedge clk); cs_n = 1'b0; rw = 1'b0;
    @(negedge clk); cs_n = 1'b1; rw = 1'b1;
  endtask

  task automatic read(output int v, output int v1);
    @(negedge clk); cs_n = 1'b0; rw = 1'b1;
    #1 v = int'(rdata); v1 = int'(rdata1);
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic t_reset;
    int v, v1;
    chk(irq_n === 1'b1, "R11 irq after reset", int'(irq_n), 1);
    chk(rdata === 16'd0, "R9 rdata idle bus", int'(rdata), 0);
    align; pin = 1'b1; hold(4); pin = 1'b0; hold(4);
    chk(irq_n === 1'b1, "R11 idle ignores pulse irq", int'(irq_n), 1);
    read(v, v1);
    chk(v == 0, "R11 idle count zero", v, 0);
  endtask

  task automatic t_clean;
    int v, v1;
    arm; align; hold(3); pin = 1'b1; hold(10); pin = 1'b0; hold(4);
    chk(irq_n === 1'b0, "R7 irq after clean pulse", int'(irq_n), 0);
    read(v, v1);
    chk(v == 9, "R1 R5 clean pulse count", v, 9);
    @(negedge clk);
    chk(irq_n === 1'b1, "R8 read releases irq", int'(irq_n), 1);
    chk(rdata === 16'd0, "R9 rdata zero outside read", int'(rdata), 0);
    align; pin = 1'b1; hold(5); pin = 1'b0; hold(4);
    chk(irq_n === 1'b1, "R7 lockout irq", int'(irq_n), 1);
    read(v, v1);
    chk(v == 9, "R7 lockout count held", v, 9);
  endtask

  task automatic t_arm_clears;
    int v, v1;
    arm; align; hold(2); pin = 1'b1; hold(3); pin = 1'b0; hold(4);
    chk(irq_n === 1'b0, "R8 irq held before read", int'(irq_n), 0);
    hold(2);
    chk(irq_n === 1'b0, "R8 irq still held", int'(irq_n), 0);
    arm;
    chk(irq_n === 1'b1, "R2 arm releases irq", int'(irq_n), 1);
    read(v, v1);
    chk(v == 0, "R2 arm clears count", v, 0);
  endtask

  task automatic t_midpulse;
    int v, v1;
    align; pin = 1'b1; hold(2); arm; align; hold(5);
    pin = 1'b0; hold(3); pin = 1'b1; hold(4); pin = 1'b0; hold(4);
    read(v, v1);
    chk(v == 3, "R3 arm during pulse waits for low", v, 3);
  endtask

  task automatic t_lead_glitch;
    int v, v1;
    arm; align; hold(3); pin = 1'b1; hold(1); pin = 1'b0; hold(3);
    chk(irq_n === 1'b1, "R4 spike gives no irq", int'(irq_n), 1);
    pin = 1'b1; hold(6); pin = 1'b0; hold(4);
    chk(irq_n === 1'b0, "R4 real pulse after spike irq", int'(irq_n), 0);
    read(v, v1);
    chk(v == 5, "R4 count after spike", v, 5);
  endtask

  task automatic t_trail_glitch;
    int v, v1;
    arm; align; hold(3); pin = 1'b1; hold(5); pin = 1'b0; hold(1);
    pin = 1'b1; hold(4); pin = 1'b0; hold(4);
    read(v, v1);
    chk(v == 7, "R6 dropout resumes count", v, 7);
  endtask

  task automatic t_saturate;
    int v, v1;
    arm; align; hold(3); pin = 1'b1; hold(20); pin = 1'b0; hold(4);
    chk(irq1_n === 1'b0, "R10 narrow irq", int'(irq1_n), 0);
    read(v, v1);
    chk(v == 19, "R5 long pulse count", v, 19);
    chk(v1 == 15, "R10 narrow counter saturates", v1, 15);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_clean;
    t_arm_clears;
    t_midpulse;
    t_lead_glitch;
    t_trail_glitch;
    t_saturate;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule